// File: doc/BRIEF.md
# Pushbutton Power Sequencing Controller

This block is a synchronous state machine. It decides when two regulator enables are driven: one for a buck converter and one for an LDO. Its inputs are a debounced active-low pushbutton, a valid-external-power flag, a buck request pin, an output-undervoltage flag and a power-on-reset flag. Debouncing and the analog comparators sit upstream, and every condition arrives as a synchronous digital level. All durations are counted in ticks of a one-cycle 1 ms enable pulse. The press-hold, power-down and wake thresholds are parameters, so short values can be used in simulation.

The controller has seven states. Both enables are low only in the hard-reset state, which is the ultralow-power state. A long press while powered on goes through a timed power-down state into hard reset. After that, a power-up needs a fresh release of the button followed by a new press. A button still held from the long press never wakes the block.

Top module: `pbseq_ctrl`

## Requirements
- R1: While reset is asserted, and until the first event after its release, the state code is 0 (hard reset) and both `buck_en` and `ldo_en` are low.
- R2: In hard reset, after the button has been seen high, holding it low for WAKE_MS consecutive ticks moves the state to power-up-1 (code 2). This happens on the clock edge that samples the last tick. In power-up-1, `ldo_en` is high and `buck_en` is low.
- R3: Each power-up state (code 2 or 3) lasts RAMP_MS ticks and then enters power-on (code 4). `buck_en` is high in power-on and in no other state.
- R4: In power-on, holding the button low for HOLD_MS consecutive ticks moves the state to power-down-1 (code 5), where `buck_en` is low and `ldo_en` is high. A press released before HOLD_MS ticks leaves the state in power-on.
- R5: Power-down-1 lasts OFFDLY_MS ticks and then enters hard reset (code 0), with `ldo_en` low.
- R6: A button held low from the long press through power-down-1 and into hard reset causes no power-up, however long it is held. Only a release followed by a new WAKE_MS press does.
- R7: In power-off (code 1), with `por_flag` low, a high `ext_pwr_ok` moves the state to power-up-2 (code 3) on the next clock edge.
- R8: In power-off, with `ext_pwr_ok` low, the state moves to power-on on the next edge while `buck_req` is high and `out_uv` is low. While `out_uv` is high, it stays in power-off.
- R9: `por_flag` high in any state other than hard reset and power-down-1 moves the state to power-down-1 on the next edge. This takes priority over every other condition.
- R10: In power-on, with `por_flag` low, `out_uv` high moves the state to power-down-2 (code 6) on the next edge. Power-down-2 lasts OFFDLY_MS ticks and then enters power-off. `ldo_en` stays high throughout power-down-2 and power-off.
- R11: `pb_stat` is high exactly when the state is power-on and `btn_n` is low.
- R12: The state code takes only the values 0 to 6: 0 hard reset, 1 power-off, 2 power-up-1, 3 power-up-2, 4 power-on, 5 power-down-1, 6 power-down-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| btn_n | input | 1 | Debounced pushbutton, low when pressed |
| ext_pwr_ok | input | 1 | Valid external power present |
| buck_req | input | 1 | Buck request pin |
| out_uv | input | 1 | Output undervoltage condition |
| por_flag | input | 1 | Power-on-reset condition (output collapsed) |
| buck_en | output | 1 | Buck converter enable |
| ldo_en | output | 1 | LDO enable |
| pb_stat | output | 1 | High while the button is pressed in power-on |
| state_code | output | 3 | Current state, encoded as in R12 |

## Verification
The hardest situation to reach is a button held continuously from the long press, through the whole power-down-1 delay and on into hard reset. Random stimulus almost never keeps the button low for that whole span. The bench therefore keeps `btn_n` low across the full hold-plus-delay sequence and then holds it well beyond the wake threshold. It then confirms that the block stays in hard reset. Only after that does it release and press again, to show that the wake path still works.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;

  typedef enum logic [2:0] {
    ST_HR  = 3'd0,
    ST_OFF = 3'd1,
    ST_UP1 = 3'd2,
    ST_UP2 = 3'd3,
    ST_ON  = 3'd4,
    ST_DN1 = 3'd5,
    ST_DN2 = 3'd6
  } pb_state_e;

endpackage

// File: rtl/pbseq_timer.sv
// Tick counter: counts enabled ticks, flags the tick that reaches LIMIT.
module pbseq_timer #(
  parameter int LIMIT = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cnt_en,
  output logic hit
);
  localparam int W = $clog2(LIMIT) + 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit = cnt_en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (cnt_en && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pbseq_fsm.sv
// Next-state decision and output decode.
module pbseq_fsm
  import pbseq_pkg::*;
(
  input  pb_state_e state_q,
  input  logic      ext_pwr_ok,
  input  logic      buck_req,
  input  logic      out_uv,
  input  logic      por_flag,
  input  logic      wake_hit,
  input  logic      hold_hit,
  input  logic      ramp_hit,
  input  logic      offdly_hit,
  output pb_state_e state_d,
  output logic      buck_on,
  output logic      ldo_on
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HR: begin
        if (wake_hit) state_d = ST_UP1;
      end
      ST_OFF: begin
        if (por_flag)                 state_d = ST_DN1;
        else if (ext_pwr_ok)          state_d = ST_UP2;
        else if (buck_req && !out_uv) state_d = ST_ON;
      end
      ST_UP1, ST_UP2: begin
        if (por_flag)      state_d = ST_DN1;
        else if (ramp_hit) state_d = ST_ON;
      end
      ST_ON: begin
        if (por_flag || hold_hit) state_d = ST_DN1;
        else if (out_uv)          state_d = ST_DN2;
      end
      ST_DN2: begin
        if (por_flag)        state_d = ST_DN1;
        else if (offdly_hit) state_d = ST_OFF;
      end
      ST_DN1: begin
        if (offdly_hit) state_d = ST_HR;
      end
      default: state_d = ST_HR;
    endcase
  end

  assign buck_on = (state_q == ST_ON);
  assign ldo_on  = (state_q != ST_HR);
endmodule

// File: rtl/pbseq_ctrl.sv
module pbseq_ctrl
  import pbseq_pkg::*;
#(
  parameter int HOLD_MS   = 14000,
  parameter int OFFDLY_MS = 1000,
  parameter int WAKE_MS   = 400,
  parameter int RAMP_MS   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       btn_n,
  input  logic       ext_pwr_ok,
  input  logic       buck_req,
  input  logic       out_uv,
  input  logic       por_flag,
  output logic       buck_en,
  output logic       ldo_en,
  output logic       pb_stat,
  output logic [2:0] state_code
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pb_state_e state_q, state_d;
  logic      seen_rel_q, seen_rel_d;
  logic      state_chg, in_up, in_dn;
  logic      press_clr, press_en, dwell_up_en, dwell_dn_en;
  logic      wake_hit, hold_hit, ramp_hit, offdly_hit;
  logic      buck_on, ldo_on;

  assign state_chg   = (state_d != state_q);
  assign in_up       = (state_q == ST_UP1) || (state_q == ST_UP2);
  assign in_dn       = (state_q == ST_DN1) || (state_q == ST_DN2);
  assign press_clr   = state_chg || btn_n || !seen_rel_q;
  assign press_en    = tick_ms && !btn_n && seen_rel_q;
  assign dwell_up_en = tick_ms && in_up;
  assign dwell_dn_en = tick_ms && in_dn;

  // Press timers: wake threshold and long-hold threshold share conditions.
  pbseq_timer #(.LIMIT(WAKE_MS)) u_wake (
    .clk(clk), .rst_n(rst_ni), .clr(press_clr), .cnt_en(press_en), .hit(wake_hit)
  );
  pbseq_timer #(.LIMIT(HOLD_MS)) u_hold (
    .clk(clk), .rst_n(rst_ni), .clr(press_clr), .cnt_en(press_en), .hit(hold_hit)
  );
  // Dwell timers for power-up ramp and power-down delay.
  pbseq_timer #(.LIMIT(RAMP_MS)) u_ramp (
    .clk(clk), .rst_n(rst_ni), .clr(state_chg), .cnt_en(dwell_up_en), .hit(ramp_hit)
  );
  pbseq_timer #(.LIMIT(OFFDLY_MS)) u_offdly (
    .clk(clk), .rst_n(rst_ni), .clr(state_chg), .cnt_en(dwell_dn_en), .hit(offdly_hit)
  );

  pbseq_fsm u_fsm (
    .state_q    (state_q),
    .ext_pwr_ok (ext_pwr_ok),
    .buck_req   (buck_req),
    .out_uv     (out_uv),
    .por_flag   (por_flag),
    .wake_hit   (wake_hit),
    .hold_hit   (hold_hit),
    .ramp_hit   (ramp_hit),
    .offdly_hit (offdly_hit),
    .state_d    (state_d),
    .buck_on    (buck_on),
    .ldo_on     (ldo_on)
  );

  // Release tracker: cleared on entry to power-down-1, set by a high button.
  always_comb begin
    seen_rel_d = seen_rel_q;
    if (state_chg && (state_d == ST_DN1)) seen_rel_d = 1'b0;
    else if (btn_n)                       seen_rel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HR;
      seen_rel_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      seen_rel_q <= seen_rel_d;
    end
  end

  assign buck_en    = buck_on;
  assign ldo_en     = ldo_on;
  assign pb_stat    = (state_q == ST_ON) && !btn_n;
  assign state_code = state_q;
endmodule

// File: rtl/pbseq_ctrl_chk.sv
module pbseq_ctrl_chk
  import pbseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       btn_n,
  input logic       ext_pwr_ok,
  input logic       por_flag,
  input logic       buck_en,
  input logic       ldo_en,
  input logic       pb_stat,
  input logic [2:0] state_code
);
  p_buck_only_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buck_en |-> (state_code == ST_ON));

  p_hr_ldo_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_HR) |-> !ldo_en);

  p_hr_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_HR) |=> (state_code == ST_HR) || (state_code == ST_UP1));

  p_off_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_OFF) && ext_pwr_ok && !por_flag |=> (state_code == ST_UP2));

  p_por_dn1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    por_flag && (state_code != ST_HR) && (state_code != ST_DN1) |=> (state_code == ST_DN1));

  p_pbstat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pb_stat == ((state_code == ST_ON) && !btn_n));

  p_code_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    state_code != 3'd7);
endmodule

bind pbseq_ctrl pbseq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .btn_n      (btn_n),
  .ext_pwr_ok (ext_pwr_ok),
  .por_flag   (por_flag),
  .buck_en    (buck_en),
  .ldo_en     (ldo_en),
  .pb_stat    (pb_stat),
  .state_code (state_code)
);

// File: tb/pbseq_ctrl_tb.sv
module pbseq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_HOLD = 14;
  localparam int T_OFF  = 5;
  localparam int T_WAKE = 4;
  localparam int T_RAMP = 3;
  localparam int WDOG_CYCLES = 20000;

  localparam int C_HR = 0, C_OFF = 1, C_UP1 = 2, C_UP2 = 3, C_ON = 4, C_DN1 = 5, C_DN2 = 6;

  logic clk = 1'b0;
  logic rst_n, tick_ms, btn_n, ext_pwr_ok, buck_req, out_uv, por_flag;
  logic buck_en, ldo_en, pb_stat;
  logic [2:0] state_code;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbseq_ctrl #(
    .HOLD_MS(T_HOLD), .OFFDLY_MS(T_OFF), .WAKE_MS(T_WAKE), .RAMP_MS(T_RAMP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_n(btn_n),
    .ext_pwr_ok(ext_pwr_ok), .buck_req(buck_req), .out_uv(out_uv),
    .por_flag(por_flag), .buck_en(buck_en), .ldo_en(ldo_en),
    .pb_stat(pb_stat), .state_code(state_code)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic release_press();
    @(negedge clk) btn_n = 1'b1;
    @(negedge clk) btn_n = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick_ms = 1'b0; btn_n = 1'b0; ext_pwr_ok = 1'b0;
    buck_req = 1'b0; out_uv = 1'b0; por_flag = 1'b0;
    cyc(3);
    check("R1", "state in reset", state_code, C_HR);
    check("R1", "buck in reset", buck_en, 0);
    check("R1", "ldo in reset", ldo_en, 0);
    @(negedge clk) rst_n = 1'b1;
    cyc(3);
    check("R1", "state after release", state_code, C_HR);
    check("R1", "ldo after release", ldo_en, 0);
  endtask

  // Button held since reset: never seen high, so no wake.
  task automatic t_wake();
    ticks(T_WAKE + 2);
    check("R6", "held since reset stays HR", state_code, C_HR);
    release_press();
    ticks(T_WAKE - 1);
    check("R2", "one tick short of wake", state_code, C_HR);
    ticks(1);
    check("R2", "wake to UP1", state_code, C_UP1);
    check("R2", "ldo in UP1", ldo_en, 1);
    check("R2", "buck in UP1", buck_en, 0);
  endtask

  task automatic t_powerup();
    ticks(T_RAMP - 1);
    check("R3", "still ramping", state_code, C_UP1);
    check("R3", "buck off while ramping", buck_en, 0);
    ticks(1);
    check("R3", "ramp done to ON", state_code, C_ON);
    check("R3", "buck on in ON", buck_en, 1);
    check("R11", "pb_stat while held in ON", pb_stat, 1);
    @(negedge clk) btn_n = 1'b1;
    cyc(1);
    check("R11", "pb_stat after release", pb_stat, 0);
  endtask

  task automatic t_short_press();
    @(negedge clk) btn_n = 1'b0;
    ticks(T_HOLD - 1);
    @(negedge clk) btn_n = 1'b1;
    cyc(1);
    check("R4", "short press stays ON", state_code, C_ON);
    ticks(2);
    check("R4", "still ON after release", state_code, C_ON);
  endtask

  task automatic t_long_press();
    @(negedge clk) btn_n = 1'b0;
    ticks(T_HOLD);
    check("R4", "long press to DN1", state_code, C_DN1);
    check("R4", "buck off in DN1", buck_en, 0);
    check("R4", "ldo on in DN1", ldo_en, 1);
    ticks(T_OFF - 1);
    check("R5", "DN1 before delay end", state_code, C_DN1);
    ticks(1);
    check("R5", "DN1 delay to HR", state_code, C_HR);
    check("R5", "ldo off in HR", ldo_en, 0);
    ticks(T_WAKE + 3);
    check("R6", "held through DN1 no wake", state_code, C_HR);
    release_press();
    ticks(T_WAKE);
    check("R6", "fresh press wakes", state_code, C_UP1);
    @(negedge clk) btn_n = 1'b1;
    ticks(T_RAMP);
    check("R3", "second ramp to ON", state_code, C_ON);
  endtask

  task automatic t_uvlo();
    @(negedge clk) out_uv = 1'b1;
    cyc(1);
    check("R10", "uv in ON to DN2", state_code, C_DN2);
    check("R10", "buck off in DN2", buck_en, 0);
    check("R10", "ldo on in DN2", ldo_en, 1);
    @(negedge clk) out_uv = 1'b0;
    ticks(T_OFF - 1);
    check("R10", "DN2 before delay end", state_code, C_DN2);
    ticks(1);
    check("R10", "DN2 delay to OFF", state_code, C_OFF);
    check("R10", "ldo on in OFF", ldo_en, 1);
  endtask

  task automatic t_ext();
    cyc(3);
    check("R8", "OFF idle", state_code, C_OFF);
    @(negedge clk) ext_pwr_ok = 1'b1;
    cyc(1);
    check("R7", "ext power to UP2", state_code, C_UP2);
    @(negedge clk) ext_pwr_ok = 1'b0;
    ticks(T_RAMP);
    check("R3", "UP2 ramp to ON", state_code, C_ON);
    @(negedge clk) out_uv = 1'b1;
    @(negedge clk) out_uv = 1'b0;
    ticks(T_OFF);
    check("R10", "back to OFF", state_code, C_OFF);
  endtask

  task automatic t_enpin();
    @(negedge clk) begin buck_req = 1'b1; out_uv = 1'b1; end
    cyc(3);
    check("R8", "uv blocks power-on", state_code, C_OFF);
    @(negedge clk) out_uv = 1'b0;
    cyc(1);
    check("R8", "req to ON", state_code, C_ON);
    check("R8", "buck on", buck_en, 1);
    @(negedge clk) buck_req = 1'b0;
  endtask

  task automatic t_por();
    @(negedge clk) por_flag = 1'b1;
    cyc(1);
    check("R9", "por in ON to DN1", state_code, C_DN1);
    @(negedge clk) por_flag = 1'b0;
    ticks(T_OFF);
    check("R9", "por path ends in HR", state_code, C_HR);
    check("R12", "HR code", state_code, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > WDOG_CYCLES) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WDOG_CYCLES);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wake();
    t_powerup();
    t_short_press();
    t_long_press();
    t_uvlo();
    t_ext();
    t_enpin();
    t_por();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule